// File: doc/BRIEF.md
# Crate Bus Function Decoder with Attention Flag

This block sits between the crate backplane and the internals of a readout module. It looks at the function code and subaddress on the bus. It watches the two bus strobes and the bus-wide clear line. It also looks at three internal status signals: busy, readout enabled, and attention request. From these it produces the command accept response (X), the status response (Q), one-cycle internal command strobes, and the attention output that asks the crate controller for service.

Each strobe line passes through a minimum-duration filter. The filter counts clock cycles, and a strobe takes effect only after it has stayed high for a set number of cycles, so short glitches are ignored. The attention request is held in a set/reset flag. The flag is set by the start of a readout or by an internal request. It is cleared by the bus clear line or by two clearing functions. A status enable bit masks its output.

The block recognises four function codes:
- F2: read the next data word.
- F8: test attention.
- F9: clear the module.
- F10: clear attention.

Top module: `bus_func_decoder`

## Requirements
- R1: X and Q respond only after strobe1In has been sampled high on HOLD_CYC consecutive rising edges (default 3). X and Q follow one edge later. A strobe1In pulse shorter than HOLD_CYC edges leaves X and Q low. X and Q fall within two edges after strobe1In drops.
- R2: Actions tied to strobe2In happen only after strobe2In has been sampled high on HOLD_CYC consecutive edges. Each accepted strobe2In pulse causes exactly one action, however long the pulse lasts. A shorter pulse causes none.
- R3: During an accepted strobe1In, X is high for the function codes 2, 8, 9 and 10 (the 5-bit busFunc value). For every other code, both X and Q stay low.
- R4: For function 2, Q is high only when rdEnableIn is high and busyIn is low.
- R5: Q for the other functions works as follows:
  - Function 8: Q equals lamOut.
  - Function 9: Q is always high.
  - Function 10: Q is high only when busSub is 0.
- R6: The attention flag is set one edge after either of two causes: rdEnableIn rises (a change from low to high), or lamReqIn is sampled high. Holding rdEnableIn high does not set the flag again after it has been cleared.
- R7: The attention flag is cleared by any of these:
  - busClearIn sampled high.
  - Function 9 with an accepted strobe2In.
  - Function 10 with busSub equal to 0 and an accepted strobe2In.
  Function 10 with any other subaddress leaves the flag unchanged.
- R8: When a set cause and a clear cause occur on the same edge, the flag ends cleared.
- R9: lamOut is the flag gated by lamEnableIn. With the enable low, lamOut is low but the flag keeps its state, and lamOut shows the flag again once the enable returns.
- R10: readNextStb pulses high for one cycle on an accepted strobe2In with function 2, but only while data is available (rdEnableIn high and busyIn low). moduleClrStb pulses high for one cycle on an accepted strobe2In with function 9.
- R11: After reset, xResp, qResp, lamOut, readNextStb and moduleClrStb are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busFunc | input | 5 | Bus function code |
| busSub | input | 4 | Bus subaddress |
| strobe1In | input | 1 | Raw first bus strobe |
| strobe2In | input | 1 | Raw second bus strobe |
| busClearIn | input | 1 | Bus-wide clear line |
| busyIn | input | 1 | Module is converting or otherwise busy |
| rdEnableIn | input | 1 | Readout-enable command level |
| lamReqIn | input | 1 | Internal attention request |
| lamEnableIn | input | 1 | Status bit that enables the attention output |
| xResp | output | 1 | Command accepted response |
| qResp | output | 1 | Status response |
| lamOut | output | 1 | Masked attention request |
| readNextStb | output | 1 | One-cycle strobe to advance to the next data word |
| moduleClrStb | output | 1 | One-cycle module clear strobe |

## Verification
Results are due at different points after each stimulus:
- X and Q: one edge after the filter accepts strobe1In. With the default setting, that is after the fourth edge on which strobe1In is seen high.
- strobe2In actions: the command strobes and the flag clear land on that same fourth edge.
- Flag set and clear from direct inputs: visible after the first edge that samples the cause.

The bench drives inputs on the falling clock edge and waits an exact number of rising edges. It then samples on the next falling edge. It also samples one edge early to confirm that nothing has appeared yet, and it samples after the strobe drops to confirm that pulses last one cycle.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

  localparam int FUNC_W = 5;
  localparam int SUB_W  = 4;

  localparam logic [FUNC_W-1:0] FN_READ     = 5'd2;
  localparam logic [FUNC_W-1:0] FN_TEST_LAM = 5'd8;
  localparam logic [FUNC_W-1:0] FN_CLR_MOD  = 5'd9;
  localparam logic [FUNC_W-1:0] FN_CLR_LAM  = 5'd10;

  typedef struct packed {
    logic xNext;
    logic qNext;
    logic readNext;
    logic moduleClr;
    logic lamSet;
    logic lamClr;
  } cmd_t;

  function automatic logic isImplemented(input logic [FUNC_W-1:0] f);
    return (f == FN_READ) || (f == FN_TEST_LAM) ||
           (f == FN_CLR_MOD) || (f == FN_CLR_LAM);
  endfunction

endpackage

// File: rtl/strobe_filter.sv
module strobe_filter #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
      filtOut <= 1'b0;
    end else if (!rawIn) begin
      holdCnt <= '0;
      filtOut <= 1'b0;
    end else if (holdCnt == LAST) begin
      filtOut <= 1'b1;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // R1 / R2: an accepted strobe rises only while the raw line was high
  p_filt_rise_held_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(filtOut) |-> $past(rawIn));

  // R1 / R2: a dropped raw line removes the filtered level on the next edge
  p_filt_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rawIn |=> !filtOut);

endmodule

// File: rtl/bfd_control.sv
module bfd_control
  import bfd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FUNC_W-1:0] busFunc,
  input  logic [SUB_W-1:0]  busSub,
  input  logic              s1Filt,
  input  logic              s2Filt,
  input  logic              busClearIn,
  input  logic              busyIn,
  input  logic              rdEnableIn,
  input  logic              lamReqIn,
  input  logic              lamOutIn,
  output cmd_t              cmd
);
  logic s2Prev;
  logic rdPrev;
  logic s2Pulse;
  logic subZero;
  logic dataReady;
  logic qSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Prev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      s2Prev <= s2Filt;
      rdPrev <= rdEnableIn;
    end
  end

  assign s2Pulse   = s2Filt & ~s2Prev;
  assign subZero   = (busSub == '0);
  assign dataReady = rdEnableIn & ~busyIn;

  always_comb begin
    case (busFunc)
      FN_READ:     qSel = dataReady;
      FN_TEST_LAM: qSel = lamOutIn;
      FN_CLR_MOD:  qSel = 1'b1;
      FN_CLR_LAM:  qSel = subZero;
      default:     qSel = 1'b0;
    endcase
  end

  always_comb begin
    cmd           = '0;
    cmd.xNext     = s1Filt & isImplemented(busFunc);
    cmd.qNext     = s1Filt & qSel;
    cmd.readNext  = s2Pulse & (busFunc == FN_READ) & dataReady;
    cmd.moduleClr = s2Pulse & (busFunc == FN_CLR_MOD);
    cmd.lamSet    = (rdEnableIn & ~rdPrev) | lamReqIn;
    cmd.lamClr    = busClearIn | cmd.moduleClr |
                    (s2Pulse & (busFunc == FN_CLR_LAM) & subZero);
  end

  // R2: one accepted strobe gives a single read advance
  p_single_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.readNext |=> !cmd.readNext);

endmodule

// File: rtl/bfd_datapath.sv
module bfd_datapath
  import bfd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  cmd_t cmd,
  input  logic lamEnableIn,
  output logic xResp,
  output logic qResp,
  output logic lamOut,
  output logic readNextStb,
  output logic moduleClrStb
);
  logic lamFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lamFlag      <= 1'b0;
      xResp        <= 1'b0;
      qResp        <= 1'b0;
      readNextStb  <= 1'b0;
      moduleClrStb <= 1'b0;
    end else begin
      if (cmd.lamClr)      lamFlag <= 1'b0;
      else if (cmd.lamSet) lamFlag <= 1'b1;
      xResp        <= cmd.xNext;
      qResp        <= cmd.qNext;
      readNextStb  <= cmd.readNext;
      moduleClrStb <= cmd.moduleClr;
    end
  end

  assign lamOut = lamFlag & lamEnableIn;

  // R8: clear wins over set
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.lamClr |=> !lamFlag);

  // R6: a set cause without a clear leaves the flag set
  p_set_takes_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.lamSet && !cmd.lamClr) |=> lamFlag);

  // R3: status is only reported for an accepted command
  p_q_needs_x_r3: assert property (@(posedge clk) disable iff (!rstN)
    qResp |-> xResp);

endmodule

// File: rtl/bus_func_decoder.sv
module bus_func_decoder
  import bfd_pkg::*;
#(
  parameter int HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FUNC_W-1:0] busFunc,
  input  logic [SUB_W-1:0]  busSub,
  input  logic              strobe1In,
  input  logic              strobe2In,
  input  logic              busClearIn,
  input  logic              busyIn,
  input  logic              rdEnableIn,
  input  logic              lamReqIn,
  input  logic              lamEnableIn,
  output logic              xResp,
  output logic              qResp,
  output logic              lamOut,
  output logic              readNextStb,
  output logic              moduleClrStb
);
  localparam int N_STB = 2;

  logic [N_STB-1:0] rawStb;
  logic [N_STB-1:0] filtStb;
  cmd_t             cmd;

  assign rawStb = {strobe2In, strobe1In};

  for (genvar gi = 0; gi < N_STB; gi++) begin : g_filt
    strobe_filter #(.HOLD_CYC(HOLD_CYC)) i_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawStb[gi]),
      .filtOut(filtStb[gi])
    );
  end

  bfd_control i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busFunc   (busFunc),
    .busSub    (busSub),
    .s1Filt    (filtStb[0]),
    .s2Filt    (filtStb[1]),
    .busClearIn(busClearIn),
    .busyIn    (busyIn),
    .rdEnableIn(rdEnableIn),
    .lamReqIn  (lamReqIn),
    .lamOutIn  (lamOut),
    .cmd       (cmd)
  );

  bfd_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .lamEnableIn (lamEnableIn),
    .xResp       (xResp),
    .qResp       (qResp),
    .lamOut      (lamOut),
    .readNextStb (readNextStb),
    .moduleClrStb(moduleClrStb)
  );

endmodule

// File: tb/test_bus_func_decoder.sv
module test_bus_func_decoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] busFunc = '0;
  logic [3:0] busSub = '0;
  logic       strobe1In = 0, strobe2In = 0, busClearIn = 0, busyIn = 0;
  logic       rdEnableIn = 0, lamReqIn = 0, lamEnableIn = 1;
  logic       xResp, qResp, lamOut, readNextStb, moduleClrStb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  bus_func_decoder i_bus_func_decoder (
    .clk(clk), .rstN(rstN), .busFunc(busFunc), .busSub(busSub),
    .strobe1In(strobe1In), .strobe2In(strobe2In), .busClearIn(busClearIn),
    .busyIn(busyIn), .rdEnableIn(rdEnableIn), .lamReqIn(lamReqIn),
    .lamEnableIn(lamEnableIn), .xResp(xResp), .qResp(qResp), .lamOut(lamOut),
    .readNextStb(readNextStb), .moduleClrStb(moduleClrStb)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runS1(input logic [4:0] f, input logic [3:0] s,
                       input logic expX, input logic expQ, input string tag);
    busFunc = f; busSub = s; strobe1In = 1;
    edges(3);
    check(xResp, 1'b0, {tag, " X not yet"});
    edges(1);
    check(xResp, expX, {tag, " X"});
    check(qResp, expQ, {tag, " Q"});
    strobe1In = 0;
    edges(2);
    check(xResp, 1'b0, {tag, " X released"});
  endtask

  task automatic runS2(input logic [4:0] f, input logic [3:0] s,
                       input logic expRd, input logic expMc, input logic expLam,
                       input string tag);
    busFunc = f; busSub = s; strobe2In = 1;
    edges(4);
    check(readNextStb, expRd, {tag, " readNextStb"});
    check(moduleClrStb, expMc, {tag, " moduleClrStb"});
    check(lamOut, expLam, {tag, " lamOut"});
    edges(2);
    check(readNextStb, 1'b0, {tag, " readNextStb single R2"});
    check(moduleClrStb, 1'b0, {tag, " moduleClrStb single R2"});
    strobe2In = 0;
    edges(2);
  endtask

  task automatic setFlag();
    lamReqIn = 1; edges(1); lamReqIn = 0;
  endtask

  task automatic t_reset();
    edges(1);
    check(xResp, 0, "R11 xResp"); check(qResp, 0, "R11 qResp");
    check(lamOut, 0, "R11 lamOut"); check(readNextStb, 0, "R11 readNextStb");
    check(moduleClrStb, 0, "R11 moduleClrStb");
  endtask

  task automatic t_s1_filter();
    busFunc = 5'd9; strobe1In = 1;
    edges(2); strobe1In = 0;
    edges(3);
    check(xResp, 0, "R1 short strobe1 X");
    check(qResp, 0, "R1 short strobe1 Q");
    runS1(5'd9, 4'd0, 1, 1, "R1 held strobe1 F9");
  endtask

  task automatic t_codes();
    for (int c = 0; c < 32; c += 5) begin
      logic impl;
      impl = (c == 2) || (c == 8) || (c == 9) || (c == 10);
      runS1(5'(c), 4'd0, impl, impl && (c == 9 || c == 10), "R3 code");
    end
    runS1(5'd8, 4'd1, 1, 0, "R3 F8 flag clear");
  endtask

  task automatic t_q_read();
    rdEnableIn = 0; busyIn = 0; runS1(5'd2, 0, 1, 0, "R4 no readout");
    rdEnableIn = 1; busyIn = 1; runS1(5'd2, 0, 1, 0, "R4 busy");
    busyIn = 0;                 runS1(5'd2, 0, 1, 1, "R4 data ready");
    runS2(5'd2, 0, 1, 0, 1, "R10 read advance");
    busyIn = 1; runS2(5'd2, 0, 0, 0, 1, "R10 busy no advance");
    busyIn = 0;
  endtask

  task automatic t_lam();
    // flag was set by rdEnableIn rising in t_q_read (R6)
    check(lamOut, 1, "R6 set by readout enable rise");
    runS1(5'd8, 0, 1, 1, "R5 F8 Q follows lamOut");
    runS1(5'd10, 4'd5, 1, 0, "R5 F10 nonzero sub Q");
    runS2(5'd10, 4'd5, 0, 0, 1, "R7 F10 nonzero sub keeps flag");
    runS2(5'd10, 4'd0, 0, 0, 0, "R7 F10 sub0 clears");
    edges(2);
    check(lamOut, 0, "R6 held enable does not set again");
    setFlag(); check(lamOut, 1, "R6 set by lamReqIn");
    runS2(5'd9, 4'd3, 0, 1, 0, "R7 F9 clears");
    setFlag();
    busClearIn = 1; edges(1); busClearIn = 0;
    check(lamOut, 0, "R7 busClearIn clears");
  endtask

  task automatic t_s2_glitch();
    setFlag();
    busFunc = 5'd10; busSub = 0; strobe2In = 1;
    edges(2); strobe2In = 0; edges(3);
    check(lamOut, 1, "R2 short strobe2 no clear");
  endtask

  task automatic t_priority();
    busClearIn = 1; lamReqIn = 1; edges(1);
    check(lamOut, 0, "R8 clear beats set");
    busClearIn = 0; edges(1);
    check(lamOut, 1, "R8 set after clear removed");
    lamReqIn = 0;
  endtask

  task automatic t_mask();
    lamEnableIn = 0; edges(1);
    check(lamOut, 0, "R9 masked");
    runS1(5'd8, 0, 1, 0, "R9 F8 masked Q");
    lamEnableIn = 1; edges(1);
    check(lamOut, 1, "R9 flag kept under mask");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    t_reset();
    t_s1_filter();
    t_codes();
    t_q_read();
    t_lam();
    t_s2_glitch();
    t_priority();
    t_mask();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule